// File: doc/BRIEF.md
# Parallel Memory to Serial Chain Streamer

This block is the master end of a configuration daisy chain. It walks a byte-wide parallel memory through a 16-bit address bus and turns every byte it fetches into a serial bit stream. It also produces the chain clock that downstream devices use to shift that stream in. The block runs entirely on a single system clock. The chain clock is that clock divided by two, so a chain-clock rising or falling edge is always one system-clock edge on which the chain clock toggles.

A transfer starts on a `start` pulse, and the byte count on `byte_count` is taken at that moment. The address counts up from 0x0000 or down from 0xFFFF, as `dir_down` selects. Each byte is fetched and the address moves on the same chain-clock rising edge. Bits leave least significant first, and each one changes only on a chain-clock falling edge, so the next device can take it on the rising edge that follows. The first bit of each byte appears one and a half chain periods after its capture. A holding stage keeps the stream free of gaps. When the last bit has been delivered, the block raises `done`, parks the chain clock low, freezes the address and holds the serial line high.

Top module: `cfg_serializer`

## Requirements
- R1: While `rst` is high the block ends each cycle with `cfg_clk` low, `ser_out` high and `done` low. `mem_addr` is 0x0000 when `dir_down` is 0 and 0xFFFF when `dir_down` is 1.
- R2: While a transfer runs, `cfg_clk` inverts on every system clock, with a period of two system clocks and a high time of one clock. It stays low when no transfer runs.
- R3: A `start` pulse accepted while no transfer runs loads `mem_addr` with 0x0000 (`dir_down`=0) or 0xFFFF (`dir_down`=1) on that edge.
- R4: `mem_addr` changes only on the edge where `cfg_clk` rises, or on the edge that accepts `start`. On a rise it moves by +1 when `dir_down` is 0 and by -1 when it is 1, modulo 2^16.
- R5: The byte captured on a `cfg_clk` rising edge is the value of `mem_data` at the address presented before that edge.
- R6: A captured byte leaves on `ser_out` bit 0 first and bit 7 last, one bit per `cfg_clk` period. Bit 0 appears on the falling edge 1.5 `cfg_clk` periods after the capturing rising edge.
- R7: `ser_out` changes only on edges where `cfg_clk` falls.
- R8: Consecutive bytes follow with no idle bit between them, one byte per 8 `cfg_clk` periods. With N>0 bytes, `done` rises 16N+4 system clocks after the edge that accepts `start`.
- R9: When all bytes have been sent, `done` is set on the falling edge one period after the last bit. From then on `cfg_clk` stays low, `ser_out` stays high and `mem_addr` holds. A byte count of 0 sets `done` on the accepting edge with no chain clock.
- R10: A `start` pulse during a running transfer is ignored. A `start` pulse while `done` is high begins a new transfer and clears `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| dir_down | input | 1 | 0: address counts up from 0x0000; 1: counts down from 0xFFFF |
| byte_count | input | 16 | Number of bytes to stream, taken at start |
| mem_addr | output | 16 | Address to the parallel memory |
| mem_data | input | 8 | Data word returned by the memory |
| cfg_clk | output | 1 | Chain clock, system clock divided by two |
| ser_out | output | 1 | Serial data to the chain, changes on cfg_clk falls |
| done | output | 1 | Transfer complete |

## Verification
The assertions watch, on every cycle, the local rules of the chain clock and the ports. They check that the chain clock never stays high for two cycles, that the address moves only on a rise or a start and then by exactly one step in the selected direction, that the serial line moves only on a fall, and that the finished state keeps the clock low, the line high and the address still. Only the bench scenarios can show the end-to-end properties: that the bits on the line are the memory bytes in LSB-first order, that the latency is exactly 1.5 periods, that bytes follow with no gap for a given count, and how a zero count, a start during a transfer and a restart behave.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_FIN
    } seq_state_e;

    // Per-edge control strobes produced by the sequencer
    typedef struct packed {
        logic go;     // accepted start
        logic cap;    // fetch byte and step address (chain clock rise)
        logic load;   // move held byte into shifter (chain clock fall)
        logic shift;  // advance shifter by one bit (chain clock fall)
        logic fin;    // last bit delivered, park outputs
    } ctl_t;

    function automatic logic [31:0] first_addr(input logic down);
        return down ? 32'hFFFF_FFFF : 32'h0000_0000;
    endfunction

    function automatic logic [31:0] next_addr(input logic [31:0] a, input logic down);
        return down ? (a - 32'd1) : (a + 32'd1);
    endfunction

endpackage

// File: rtl/cfgser_seq.sv
module cfgser_seq
    import cfgser_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] byte_count,
    output ctl_t          ctl,
    output logic          cfg_clk,
    output logic          done
);
    localparam int BW = $clog2(DW);

    seq_state_e    st;
    logic          ph;
    logic [BW-1:0] bcnt;
    logic [CW-1:0] left;
    logic          pend;
    logic          rise;
    logic          fall;

    assign rise    = (st == SQ_RUN) && !ph;
    assign fall    = (st == SQ_RUN) && ph;
    assign cfg_clk = ph;

    always_comb begin
        ctl.go    = start && (st != SQ_RUN);
        ctl.cap   = rise && (bcnt == '0) && (left != '0);
        ctl.load  = fall && (bcnt == BW'(1)) && pend;
        ctl.fin   = fall && (bcnt == BW'(1)) && !pend;
        ctl.shift = fall && (bcnt != BW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            ph   <= 1'b0;
            bcnt <= '0;
            left <= '0;
            pend <= 1'b0;
            done <= 1'b0;
        end else if (ctl.go) begin
            ph   <= 1'b0;
            bcnt <= '0;
            left <= byte_count;
            pend <= 1'b0;
            if (byte_count == '0) begin
                st   <= SQ_FIN;
                done <= 1'b1;
            end else begin
                st   <= SQ_RUN;
                done <= 1'b0;
            end
        end else if (st == SQ_RUN) begin
            ph <= ~ph;
            if (ctl.cap) begin
                left <= left - CW'(1);
                pend <= 1'b1;
            end
            if (ctl.load) begin
                pend <= 1'b0;
            end
            if (fall) begin
                bcnt <= bcnt + BW'(1);
            end
            if (ctl.fin) begin
                st   <= SQ_FIN;
                done <= 1'b1;
                bcnt <= '0;
            end
        end
    end

endmodule

// File: rtl/cfgser_addr.sv
module cfgser_addr
    import cfgser_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_down,
    input  ctl_t          ctl,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst || ctl.go) begin
            addr <= AW'(first_addr(dir_down));
        end else if (ctl.cap) begin
            addr <= AW'(next_addr(32'(addr), dir_down));
        end
    end

endmodule

// File: rtl/cfgser_shift.sv
module cfgser_shift
    import cfgser_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl,
    input  logic [DW-1:0] din,
    output logic          sout
);
    logic [DW-1:0] held;
    logic [DW-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (ctl.cap) begin
            held <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.go || ctl.fin) begin
            sreg <= '1;
        end else if (ctl.load) begin
            sreg <= held;
        end else if (ctl.shift) begin
            sreg <= {1'b1, sreg[DW-1:1]};
        end
    end

    assign sout = sreg[0];

endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer
    import cfgser_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dir_down,
    input  logic [CW-1:0] byte_count,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_data,
    output logic          cfg_clk,
    output logic          ser_out,
    output logic          done
);
    ctl_t ctl;

    cfgser_seq #(.DW(DW), .CW(CW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .byte_count (byte_count),
        .ctl        (ctl),
        .cfg_clk    (cfg_clk),
        .done       (done)
    );

    cfgser_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .dir_down (dir_down),
        .ctl      (ctl),
        .addr     (mem_addr)
    );

    cfgser_shift #(.DW(DW)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .din  (mem_data),
        .sout (ser_out)
    );

endmodule

// File: rtl/cfgser_chk.sv
module cfgser_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          dir_down,
    input logic [AW-1:0] mem_addr,
    input logic          cfg_clk,
    input logic          ser_out,
    input logic          done
);
    AST_CLK_HIGH_ONE: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_clk) |-> !cfg_clk); // R2

    AST_ADDR_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> ($rose(cfg_clk) || $past(start))); // R4

    AST_ADDR_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        ($rose(cfg_clk) && !$stable(mem_addr)) |->
        (mem_addr == ($past(dir_down) ? ($past(mem_addr) - AW'(1))
                                      : ($past(mem_addr) + AW'(1))))); // R4

    AST_SER_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_out) |-> $fell(cfg_clk)); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cfg_clk && ser_out)); // R9

    AST_DONE_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done) && !$past(start)) |-> $stable(mem_addr)); // R9

endmodule

bind cfg_serializer cfgser_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .dir_down (dir_down),
    .mem_addr (mem_addr),
    .cfg_clk  (cfg_clk),
    .ser_out  (ser_out),
    .done     (done)
);

// File: tb/cfg_serializer_tb.sv
`timescale 1ns/1ps
module cfg_serializer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        dir_down;
    logic [15:0] byte_count;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        cfg_clk;
    logic        ser_out;
    logic        done;
    logic [7:0]  seed;

    int nvec  = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] data_of(input logic [15:0] a, input logic [7:0] s);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ s;
    endfunction

    assign mem_data = data_of(mem_addr, seed);

    cfg_serializer u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .dir_down   (dir_down),
        .byte_count (byte_count),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .cfg_clk    (cfg_clk),
        .ser_out    (ser_out),
        .done       (done)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: event counts plus a queue of pending bits
    bit          m_ok = 0;
    bit          m_run, m_ph, m_done, m_sout;
    logic [15:0] m_addr;
    int          m_rc, m_fc, m_left;
    bit          m_q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_ph = 0; m_done = 0; m_sout = 1;
            m_addr = dir_down ? 16'hFFFF : 16'h0000;
            m_q.delete();
            m_ok = 1;
        end else if (start && !m_run) begin
            m_ph = 0; m_rc = 0; m_fc = 0; m_sout = 1;
            m_left = int'(byte_count);
            m_addr = dir_down ? 16'hFFFF : 16'h0000;
            m_q.delete();
            m_run  = (byte_count != 0);
            m_done = (byte_count == 0);
        end else if (m_run) begin
            if (!m_ph) begin
                if ((m_rc % 8) == 0 && m_left > 0) begin
                    logic [7:0] b;
                    b = data_of(m_addr, seed);
                    for (int i = 0; i < 8; i++) m_q.push_back(b[i]);
                    m_addr = dir_down ? m_addr - 16'd1 : m_addr + 16'd1;
                    m_left--;
                end
                m_rc++;
                m_ph = 1;
            end else begin
                m_ph = 0;
                if (m_fc >= 1) begin
                    if (m_q.size() > 0) m_sout = m_q.pop_front();
                    else begin
                        m_run = 0; m_done = 1; m_sout = 1;
                    end
                end
                m_fc++;
            end
        end
    end

    logic prev_ser = 1'b1;
    logic prev_cfg = 1'b0;

    always @(negedge clk) begin
        if (m_ok) begin
            check("R4", "mem_addr", 32'(mem_addr), 32'(m_addr));
            check("R2", "cfg_clk", 32'(cfg_clk), 32'(m_ph));
            check("R6", "ser_out", 32'(ser_out), 32'(m_sout)); // bit order also covers R5
            check("R9", "done", 32'(done), 32'(m_done));
            if (ser_out !== prev_ser)
                check("R7", "ser_out moved on a fall", 32'(prev_cfg && !cfg_clk), 32'd1);
            prev_ser = ser_out;
            prev_cfg = cfg_clk;
        end
    end

    // Run one transfer; optionally pulse start again mid-run (R10)
    task automatic run_xfer(input bit down, input int n, input bit poke);
        bit   bits[$];
        logic pc;
        int   cyc;
        bit   first_fall;
        dir_down   = down;
        byte_count = 16'(n);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        byte_count = 16'h0007;
        cyc = 1;
        check("R3", "start address", 32'(mem_addr), down ? 32'hFFFF : 32'h0);
        pc = cfg_clk;
        first_fall = 1;
        while (!done && cyc < 5000) begin
            if (poke && cyc == 10) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (pc && !cfg_clk && !done) begin
                if (first_fall) first_fall = 0;
                else bits.push_back(ser_out);
            end
            pc = cfg_clk;
        end
        if (n == 0) check("R9", "zero count done latency", 32'(cyc), 32'd1);
        else        check("R8", "cycles start to done", 32'(cyc), 32'(16 * n + 5));
        check("R5", "bit count", 32'(bits.size()), 32'(8 * n));
        for (int k = 0; k < n && bits.size() >= 8 * (k + 1); k++) begin
            logic [7:0] got;
            logic [15:0] a;
            for (int j = 0; j < 8; j++) got[j] = bits[8 * k + j];
            a = down ? 16'(16'hFFFF - k) : 16'(k);
            check("R5", "byte from memory LSB first", 32'(got), 32'(data_of(a, seed)));
        end
        repeat (3) @(negedge clk);
        check("R9", "done holds", 32'(done), 32'd1);
        check("R9", "line high after done", 32'(ser_out), 32'd1);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; dir_down = 1'b0; byte_count = '0; seed = 8'h11;
        repeat (4) @(negedge clk);
        check("R1", "reset addr up", 32'(mem_addr), 32'h0);
        check("R1", "reset cfg_clk", 32'(cfg_clk), 32'd0);
        check("R1", "reset ser_out", 32'(ser_out), 32'd1);
        check("R1", "reset done", 32'(done), 32'd0);
        dir_down = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "reset addr down", 32'(mem_addr), 32'hFFFF);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R2", "idle clock low", 32'(cfg_clk), 32'd0);

        run_xfer(1'b0, 3, 1'b0);
        seed = 8'hA6;
        run_xfer(1'b1, 2, 1'b0);   // restart from done (R10)
        run_xfer(1'b0, 1, 1'b0);
        run_xfer(1'b0, 0, 1'b0);
        seed = 8'h3C;
        run_xfer(1'b0, 2, 1'b1);   // mid-run start ignored (R10)
        run_xfer(1'b1, 4, 1'b0);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule